// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback), which pipeline registers must hold their contents and which must be loaded with an empty slot in the next cycle. Its inputs are the operation codes currently in the decode, execute and memory stages, the memory-result destination register of the execute-stage operation, the two source registers that decode is reading, and the branch-condition outcome produced in execute. From these it detects three situations: a load whose result is needed right away, a return travelling down the pipeline, and a conditional jump that was wrongly predicted taken.

The stall and bubble decisions are purely combinational and are applied at the next clock edge by a set of five pipeline registers that also live in this block. Each register carries an opaque payload and a valid bit, so the effect of every decision can be observed at the ports. When a load hazard and a return in decode occur together, the load hazard wins: decode is held, not emptied, and the return stays in decode for one more cycle. This keeps decode from ever being asked to hold and empty at once. A sticky error flag records any stage that receives both requests, and the control logic never causes it to rise.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A load hazard exists when the execute operation code is 5 (memory load) or 11 (pop), and its destination register equals decode source A or decode source B.
- R2: Fetch (vector bit 0) is stalled when a load hazard exists or when operation code 9 (return) is in decode, execute or memory.
- R3: Decode (bit 1) is stalled when a load hazard exists, and at no other time.
- R4: Decode receives a bubble when execute holds code 7 (conditional jump) with the condition input low, or when a return is in flight and no load hazard exists.
- R5: Execute (bit 2) receives a bubble on a mispredicted jump or on a load hazard. It is never stalled.
- R6: Memory (bit 3) and writeback (bit 4) are never stalled and never receive a bubble.
- R7: Register code 15 means no register. A destination of 15 never produces a load hazard, even when a source is also 15.
- R8: A stalled stage register keeps its payload and its valid bit across the clock edge.
- R9: A bubbled stage register loads an all-zero payload with valid low. A stage that is neither stalled nor bubbled loads its input slice (stage i uses bits i*PW to i*PW+PW-1) with valid high.
- R10: The error flag becomes 1 and stays 1 after any edge where some stage is both stalled and bubbled. Under this control logic the flag stays 0.
- R11: While reset is asserted, and until reset has been synchronously released, all payloads are zero, all valid bits are low and the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| d_op | input | 4 | Operation code in the decode stage |
| e_op | input | 4 | Operation code in the execute stage |
| m_op | input | 4 | Operation code in the memory stage |
| e_mdst | input | 4 | Memory-result destination register of the execute operation (15 = none) |
| d_src_a | input | 4 | First source register read in decode (15 = none) |
| d_src_b | input | 4 | Second source register read in decode (15 = none) |
| e_cond_ok | input | 1 | Branch condition evaluated in execute (1 = jump taken) |
| stall | output | 5 | Per-stage hold request, bit 0 = fetch to bit 4 = writeback |
| bubble | output | 5 | Per-stage empty-slot request, same bit order |
| stage_in | input | 5*PW | Payload offered to each stage register |
| stage_q | output | 5*PW | Payload held by each stage register |
| stage_vld | output | 5 | Valid bit of each stage register |
| ctl_err | output | 1 | Sticky flag: some stage was stalled and bubbled at once |

## Verification
The assertions assume that the operation-code, register and condition inputs are stable, meaningful values in every cycle after reset release. They also assume that a conditional jump and a load never occupy execute together, because the codes differ. The bench drives only legal encoded values. It sweeps every combination of a small operation set (load, pop, return, jump, no-op and one other code), of destination and source values drawn from two real registers and the none code, and of both condition levels. The coincident load-then-return case and the mispredict-with-return case are then replayed on the stage registers to observe hold and empty behaviour.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int OPW  = 4;
  localparam int RW   = 4;
  localparam int NSTG = 5;

  localparam logic [OPW-1:0] OP_NOP  = 4'h0;
  localparam logic [OPW-1:0] OP_LOAD = 4'h5;
  localparam logic [OPW-1:0] OP_JCC  = 4'h7;
  localparam logic [OPW-1:0] OP_RET  = 4'h9;
  localparam logic [OPW-1:0] OP_POP  = 4'hB;
  localparam logic [RW-1:0]  REG_NONE = 4'hF;

  typedef enum int {ST_F = 0, ST_D = 1, ST_E = 2, ST_M = 3, ST_W = 4} stage_e;
endpackage

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
(
  input  logic [OPW-1:0] d_op,
  input  logic [OPW-1:0] e_op,
  input  logic [OPW-1:0] m_op,
  input  logic [RW-1:0]  e_mdst,
  input  logic [RW-1:0]  d_src_a,
  input  logic [RW-1:0]  d_src_b,
  input  logic           e_cond_ok,
  output logic           load_use,
  output logic           ret_busy,
  output logic           mispred
);
  localparam int NSRC = 2;

  logic [RW-1:0]   srcs [NSRC];
  logic [NSRC-1:0] src_hit;
  logic            e_is_mem;

  assign srcs[0] = d_src_a;
  assign srcs[1] = d_src_b;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_hit[s] = (e_mdst != REG_NONE) && (srcs[s] == e_mdst);
  end

  always_comb begin
    e_is_mem = (e_op == OP_LOAD) || (e_op == OP_POP);
    load_use = e_is_mem && (|src_hit);
    ret_busy = (d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET);
    mispred  = (e_op == OP_JCC) && !e_cond_ok;
  end
endmodule

// File: rtl/hz_policy.sv
module hz_policy
  import hz_pkg::*;
(
  input  logic            load_use,
  input  logic            ret_busy,
  input  logic            mispred,
  output logic [NSTG-1:0] stall,
  output logic [NSTG-1:0] bubble
);
  always_comb begin
    stall  = '0;
    bubble = '0;
    stall[ST_F]  = load_use | ret_busy;
    stall[ST_D]  = load_use;
    bubble[ST_D] = mispred | (ret_busy & ~load_use);
    bubble[ST_E] = mispred | load_use;
  end
endmodule

// File: rtl/hz_stage_reg.sv
module hz_stage_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          bubble,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] q,
  output logic          vld,
  output logic          dual
);
  logic [PW-1:0] q_nx;
  logic          vld_nx;
  logic          en;

  always_comb begin
    dual   = stall & bubble;
    en     = ~stall;
    q_nx   = bubble ? '0 : d;
    vld_nx = ~bubble;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else if (en) begin
      q   <= q_nx;
      vld <= vld_nx;
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(q) && $stable(vld)));

  // R9
  empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble && !stall) |=> (!vld && q == '0));

  // R9
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble && !stall) |=> (vld && q == $past(d)));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OPW-1:0]       d_op,
  input  logic [OPW-1:0]       e_op,
  input  logic [OPW-1:0]       m_op,
  input  logic [RW-1:0]        e_mdst,
  input  logic [RW-1:0]        d_src_a,
  input  logic [RW-1:0]        d_src_b,
  input  logic                 e_cond_ok,
  output logic [NSTG-1:0]      stall,
  output logic [NSTG-1:0]      bubble,
  input  logic [NSTG*PW-1:0]   stage_in,
  output logic [NSTG*PW-1:0]   stage_q,
  output logic [NSTG-1:0]      stage_vld,
  output logic                 ctl_err
);
  logic [1:0]      rst_pipe;
  logic            rst_sync;
  logic            load_use, ret_busy, mispred;
  logic [NSTG-1:0] dual;
  logic            err_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  hz_detect u_detect (
    .d_op(d_op), .e_op(e_op), .m_op(m_op), .e_mdst(e_mdst),
    .d_src_a(d_src_a), .d_src_b(d_src_b), .e_cond_ok(e_cond_ok),
    .load_use(load_use), .ret_busy(ret_busy), .mispred(mispred)
  );

  hz_policy u_policy (
    .load_use(load_use), .ret_busy(ret_busy), .mispred(mispred),
    .stall(stall), .bubble(bubble)
  );

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    hz_stage_reg #(.PW(PW)) u_reg (
      .clk(clk), .rst_n(rst_sync),
      .stall(stall[i]), .bubble(bubble[i]),
      .d(stage_in[i*PW +: PW]), .q(stage_q[i*PW +: PW]),
      .vld(stage_vld[i]), .dual(dual[i])
    );
  end

  always_comb err_nx = ctl_err | (|dual);

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) ctl_err <= 1'b0;
    else           ctl_err <= err_nx;
  end

  // R10
  no_dual_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (stall & bubble) == '0);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !ctl_err);

  // R6
  mw_normal_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (stall[ST_W:ST_M] == '0) && (bubble[ST_W:ST_M] == '0));

  // R3
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    stall[ST_D] |-> (stall[ST_F] && bubble[ST_E] && !bubble[ST_D]));

  // R2
  ret_fetch_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (d_op == OP_RET || e_op == OP_RET || m_op == OP_RET) |-> stall[ST_F]);

  // R7
  none_reg_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (e_mdst == REG_NONE) |-> !stall[ST_D]);
endmodule

// File: tb/pipe_hazard_ctrl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_test;
  localparam int PW = 8;
  localparam int NS = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] d_op, e_op, m_op, e_mdst, d_src_a, d_src_b;
  logic e_cond_ok;
  logic [NS-1:0] stall, bubble, stage_vld;
  logic [NS*PW-1:0] stage_in, stage_q;
  logic ctl_err;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pipe_hazard_ctrl #(.PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .d_op(d_op), .e_op(e_op), .m_op(m_op),
    .e_mdst(e_mdst), .d_src_a(d_src_a), .d_src_b(d_src_b),
    .e_cond_ok(e_cond_ok), .stall(stall), .bubble(bubble),
    .stage_in(stage_in), .stage_q(stage_q), .stage_vld(stage_vld),
    .ctl_err(ctl_err)
  );

  function automatic logic [9:0] model(logic [3:0] dop, logic [3:0] eop,
      logic [3:0] mop, logic [3:0] dst, logic [3:0] sa, logic [3:0] sb,
      logic ok);
    logic lu, rb, mp;
    logic [4:0] s, b;
    lu = (eop == 4'd5 || eop == 4'd11) && dst != 4'd15 && (dst == sa || dst == sb);
    rb = (dop == 4'd9) || (eop == 4'd9) || (mop == 4'd9);
    mp = (eop == 4'd7) && !ok;
    s = 5'b0; b = 5'b0;
    s[0] = lu || rb;
    s[1] = lu;
    b[1] = mp || (rb && !lu);
    b[2] = mp || lu;
    return {b, s};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic set_ctl(logic [3:0] dop, logic [3:0] eop, logic [3:0] mop,
      logic [3:0] dst, logic [3:0] sa, logic [3:0] sb, logic ok);
    d_op = dop; e_op = eop; m_op = mop; e_mdst = dst;
    d_src_a = sa; d_src_b = sb; e_cond_ok = ok;
  endtask

  task automatic check_stage(int i, logic [7:0] q, logic v, string tag);
    check(tag, {stage_q[i*PW +: PW], stage_vld[i]}, {q, v});
  endtask

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [3:0] ops [6];
    logic [3:0] regs [3];
    ops[0] = 4'd0; ops[1] = 4'd5; ops[2] = 4'd11;
    ops[3] = 4'd9; ops[4] = 4'd7; ops[5] = 4'd3;
    regs[0] = 4'd1; regs[1] = 4'd2; regs[2] = 4'd15;

    rst_n = 1'b0;
    set_ctl(4'd0, 4'd0, 4'd0, 4'd15, 4'd15, 4'd15, 1'b1);
    stage_in = {8'hA5, 8'hA4, 8'hA3, 8'hA2, 8'hA1};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 payload", stage_q, '0);
    check("R11 valid", stage_vld, '0);
    check("R11 err", ctl_err, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 exhaustive sweep of control decisions
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++)
          for (int x = 0; x < 3; x++)
            for (int y = 0; y < 3; y++)
              for (int z = 0; z < 3; z++)
                for (int k = 0; k < 2; k++) begin
                  @(negedge clk);
                  set_ctl(ops[a], ops[b], ops[c], regs[x], regs[y], regs[z], k[0]);
                  #1;
                  check("R1 R2 R3 R4 R5 R6 R7 ctl", {bubble, stall},
                        model(ops[a], ops[b], ops[c], regs[x], regs[y], regs[z], k[0]));
                end

    // R9 normal load of every stage
    @(negedge clk);
    set_ctl(4'd0, 4'd0, 4'd0, 4'd15, 4'd1, 4'd2, 1'b1);
    stage_in = {8'h50, 8'h40, 8'h30, 8'h20, 8'h10};
    @(negedge clk);
    for (int i = 0; i < NS; i++) check_stage(i, 8'h10 * (i + 1), 1'b1, "R9 pass");

    // R8 R9 load hazard: fetch and decode hold, execute emptied
    set_ctl(4'd0, 4'd5, 4'd0, 4'd2, 4'd2, 4'd6, 1'b1);
    stage_in = {8'h51, 8'h41, 8'h31, 8'h21, 8'h11};
    @(negedge clk);
    check_stage(0, 8'h10, 1'b1, "R8 fetch hold");
    check_stage(1, 8'h20, 1'b1, "R8 decode hold");
    check_stage(2, 8'h00, 1'b0, "R9 execute bubble");
    check_stage(3, 8'h41, 1'b1, "R6 memory pass");
    check_stage(4, 8'h51, 1'b1, "R6 writeback pass");

    // R4 mispredict with return at target: fetch hold, D and E emptied
    set_ctl(4'd9, 4'd7, 4'd0, 4'd15, 4'd15, 4'd15, 1'b0);
    stage_in = {8'h52, 8'h42, 8'h32, 8'h22, 8'h12};
    #1;
    check("R4 comboA ctl", {bubble, stall}, {5'b00110, 5'b00001});
    @(negedge clk);
    check_stage(0, 8'h10, 1'b1, "R8 fetch hold A");
    check_stage(1, 8'h00, 1'b0, "R4 decode bubble A");
    check_stage(2, 8'h00, 1'b0, "R5 execute bubble A");
    check_stage(3, 8'h42, 1'b1, "R6 memory A");

    // R3 load then return reading loaded register
    set_ctl(4'd9, 4'd5, 4'd0, 4'd4, 4'd4, 4'd15, 1'b1);
    stage_in = {8'h53, 8'h43, 8'h33, 8'h23, 8'h13};
    #1;
    check("R3 comboB ctl", {bubble, stall}, {5'b00100, 5'b00011});
    @(negedge clk);
    check_stage(1, 8'h00, 1'b0, "R8 decode held B");
    check_stage(2, 8'h00, 1'b0, "R5 execute bubble B");
    check("R10 err after comboB", ctl_err, 1'b0);

    // R7 none destination never matches none sources
    set_ctl(4'd0, 4'd11, 4'd0, 4'd15, 4'd15, 4'd15, 1'b1);
    #1;
    check("R7 none", {bubble, stall}, 10'b0);
    @(negedge clk);
    check("R10 err final", ctl_err, 1'b0);

    finish_run();
  end
endmodule